// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the processor side of a bus cycle on a shared 16-bit address/data path with a 4-bit upper address/status field. An internal unit presents one request at a time. The request states memory or I/O, read or write, byte or word, an interrupt-acknowledge flag, a lock flag, a flag marking the first half of an unaligned word, the address and the write data. The controller takes the request and steps through T1, T2, T3, any number of wait states and T4. On the way it produces the latch strobe, the read, write and acknowledge strobes, the transceiver enable and direction, the memory/I/O select and the upper-byte enable.

Tristate pins are modelled as a value plus an output enable. The external latches, transceivers and clock source sit outside this block. Another master can take the bus through a hold input. That input is synchronised, and the bus is handed over only at points where the rules allow it. The controller answers with a half-cycle-timed acknowledge.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: `ale` is high for exactly the one T1 cycle of every bus cycle. During that cycle `ad_oe` is 1 and `ad_out` carries address bits 15:0. `ale` has no output enable and is low in all other states, hold included.
- R2: During T1 of a memory cycle `ahs_out` carries address bits 19:16. During T1 of an I/O cycle it is 0000. During T2 to T4 it is 0000.
- R3: The strobes are active low through T2, T3 and every wait state, and high in T1 and T4. `rd_n` serves a read that is not an acknowledge, `wr_n` serves a write, and `inta_n` serves an interrupt-acknowledge cycle. In a read, `ad_oe` is 0 from T2 to T4. In a write, `ad_out` carries the write data with `ad_oe` at 1.
- R4: `ready_in` is sampled at the clock edge that ends T3 and at the edge that ends each wait state. Each low sample adds one wait state, in which the strobes stay active.
- R5: `den_n` falls at the falling clock edge inside T2 and rises at the falling clock edge inside T4. It is high in T1.
- R6: `dt_r` is 1 throughout a write cycle and 0 throughout a read or acknowledge cycle.
- R7: `m_io` is 1 for memory and 0 for I/O. It already shows the type of the next cycle in the idle or T4 cycle in which that request is accepted. Otherwise it keeps the current cycle's type up to and including its T4.
- R8: `bhe_n` is 0 from T1 to T4 when the upper data half is used, which is a word, or a byte at an odd address. It is 1 for a byte at an even address.
- R9: `hold_in` passes through a two-flop synchroniser. From idle, the bus goes into hold on the third rising edge after `hold_in` rises. In hold, `ad_oe`, `ahs_oe` and `ctl_oe` are all 0. `hlda` rises at the falling edge that follows entry into hold.
- R10: After the synchronised hold input falls, the block leaves hold on a rising edge, drives `ctl_oe` again, and drops `hlda` at the next falling edge.
- R11: An active cycle hands over the bus straight from its T4 only when all of the following are true:
  - the synchronised hold was seen in T1 or T2;
  - the split, acknowledge and lock flags are all clear.

  Otherwise a pending request starts its T1 first.
- R12: Read data on `ad_in` is captured at the edge where `ready_in` is sampled high. `rsp_valid` is high during T4 only, with `rsp_rdata` holding the captured data.
- R13: `req_ack` is 1 only in an idle or T4 cycle in which the request is taken. T1 follows directly, so back-to-back cycles leave no idle cycle between them. No request is taken during hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_write | input | 1 | 1 write, 0 read |
| req_byte | input | 1 | 1 byte transfer, 0 word |
| req_inta | input | 1 | Interrupt-acknowledge cycle (first of pair) |
| req_lock | input | 1 | Bus locked for this cycle |
| req_split | input | 1 | Cycle is the first half of an unaligned word |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data, already placed on its lanes |
| req_ack | output | 1 | Request taken this cycle |
| rsp_valid | output | 1 | Cycle completing (T4) |
| rsp_rdata | output | 16 | Captured read data |
| ready_in | input | 1 | Slave ready, synchronous |
| hold_in | input | 1 | Asynchronous hold request |
| hlda | output | 1 | Hold acknowledge |
| ad_in | input | 16 | Shared bus input value |
| ad_out | output | 16 | Shared bus driven value |
| ad_oe | output | 1 | Shared bus output enable |
| ahs_out | output | 4 | Upper address/status value |
| ahs_oe | output | 1 | Upper address/status enable |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Acknowledge strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = out |
| m_io | output | 1 | Memory/I/O select |
| bhe_n | output | 1 | Upper byte enable, active low |
| ctl_oe | output | 1 | Enable for control outputs and `bhe_n` |

## Verification
The hardest case to reach is a hold request whose synchronised copy arrives after T2. Such a request must not release the bus at this T4, but it must release it at the end of the following cycle. The stimulus raises `hold_in` during T3 and keeps a second request waiting, then checks that T1 follows instead of hold. The blocked cases work the same way: hold is raised together with a locked, split or acknowledge request, a plain request waits behind it, and the bench confirms that release comes only after the plain cycle's T4.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_state_e;

  // attributes latched when a request is accepted
  typedef struct packed {
    logic mem;
    logic write;
    logic inta;
    logic lock;
    logic split;
    logic bhe_n;
  } cyc_attr_t;

endpackage

// File: rtl/bcc_sync.sv
module bcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_d = d;
    end else begin : g_chain
      always_comb sr_d = {sr_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_mem,
  input  logic          req_write,
  input  logic          req_byte,
  input  logic          req_inta,
  input  logic          req_lock,
  input  logic          req_split,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready_in,
  input  logic          hold_sync,
  input  logic [DW-1:0] ad_in,
  output bus_state_e    state_q,
  output cyc_attr_t     attr_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          start,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  bus_state_e    state_d;
  cyc_attr_t     attr_d;
  logic          early_q, early_d;
  logic          release_ok;
  logic          capture;
  logic          rsp_valid_q;
  logic [DW-1:0] rdata_q;

  // upper half used by a word, or by a byte at an odd address
  always_comb begin
    attr_d.mem   = req_mem;
    attr_d.write = req_write;
    attr_d.inta  = req_inta;
    attr_d.lock  = req_lock;
    attr_d.split = req_split;
    attr_d.bhe_n = ~(~req_byte | req_addr[0]);
  end

  assign release_ok = early_q & ~attr_q.split & ~attr_q.inta & ~attr_q.lock;
  assign capture    = ((state_q == ST_T3) || (state_q == ST_TW)) & ready_in;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hold_sync) begin
          state_d = ST_HOLD;
        end else if (req_valid) begin
          start   = 1'b1;
          state_d = ST_T1;
        end
      end
      ST_T1: state_d = ST_T2;
      ST_T2: state_d = ST_T3;
      ST_T3, ST_TW: state_d = ready_in ? ST_T4 : ST_TW;
      ST_T4: begin
        if (release_ok) begin
          state_d = ST_HOLD;
        end else if (req_valid) begin
          start   = 1'b1;
          state_d = ST_T1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_HOLD: if (!hold_sync) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // hold qualifies for release only if seen in T1 or T2 of this cycle
  always_comb begin
    early_d = early_q;
    if (start)
      early_d = 1'b0;
    else if (((state_q == ST_T1) || (state_q == ST_T2)) && hold_sync)
      early_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      early_q     <= 1'b0;
      attr_q      <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      early_q     <= early_d;
      rsp_valid_q <= capture;
      if (start) begin
        attr_q  <= attr_d;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= ad_in;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/bcc_pins.sv
module bcc_pins
  import bcc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_state_e       state_q,
  input  logic             cur_mem,
  input  logic             cur_write,
  input  logic             cur_inta,
  input  logic             cur_bhe_n,
  input  logic [AW-1:0]    addr_q,
  input  logic [DW-1:0]    wdata_q,
  input  logic             start,
  input  logic             req_mem,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] ahs_out,
  output logic             ahs_oe,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             inta_n,
  output logic             den_n,
  output logic             dt_r,
  output logic             m_io,
  output logic             bhe_n,
  output logic             ctl_oe,
  output logic             hlda
);

  localparam int HW = AW - DW;

  logic in_t1, in_data, in_strobe, busy, in_hold;
  logic den_act_q, hlda_q;

  assign in_t1     = (state_q == ST_T1);
  assign in_strobe = (state_q == ST_T2) || (state_q == ST_T3) || (state_q == ST_TW);
  assign in_data   = in_strobe || (state_q == ST_T4);
  assign busy      = in_t1 || in_data;
  assign in_hold   = (state_q == ST_HOLD);

  always_comb begin
    ad_oe  = in_t1 | (in_data & cur_write);
    ad_out = '0;
    if (in_t1)          ad_out = addr_q[DW-1:0];
    else if (cur_write) ad_out = wdata_q;
  end

  assign ahs_oe  = busy;
  assign ahs_out = (in_t1 && cur_mem) ? addr_q[AW-1:DW] : {HW{1'b0}};

  assign ale    = in_t1;
  assign rd_n   = ~(in_strobe & ~cur_write & ~cur_inta);
  assign wr_n   = ~(in_strobe & cur_write);
  assign inta_n = ~(in_strobe & cur_inta);
  assign dt_r   = cur_write;
  assign m_io   = start ? req_mem : cur_mem;
  assign bhe_n  = busy ? cur_bhe_n : 1'b1;
  assign ctl_oe = ~in_hold;

  // half-cycle outputs: launched on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_act_q <= 1'b0;
      hlda_q    <= 1'b0;
    end else begin
      den_act_q <= in_strobe;
      hlda_q    <= in_hold;
    end
  end

  assign den_n = ~den_act_q;
  assign hlda  = hlda_q;

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_mem,
  input  logic             req_write,
  input  logic             req_byte,
  input  logic             req_inta,
  input  logic             req_lock,
  input  logic             req_split,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ack,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  input  logic             ready_in,
  input  logic             hold_in,
  output logic             hlda,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] ahs_out,
  output logic             ahs_oe,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             inta_n,
  output logic             den_n,
  output logic             dt_r,
  output logic             m_io,
  output logic             bhe_n,
  output logic             ctl_oe
);

  bus_state_e    state_q;
  cyc_attr_t     attr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          hold_sync;
  logic          start;

  bcc_sync #(.STAGES(SYNC_STAGES)) u_hold_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hold_in),
    .q     (hold_sync)
  );

  bcc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mem   (req_mem),
    .req_write (req_write),
    .req_byte  (req_byte),
    .req_inta  (req_inta),
    .req_lock  (req_lock),
    .req_split (req_split),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ready_in  (ready_in),
    .hold_sync (hold_sync),
    .ad_in     (ad_in),
    .state_q   (state_q),
    .attr_q    (attr_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .start     (start),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  bcc_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .cur_mem   (attr_q.mem),
    .cur_write (attr_q.write),
    .cur_inta  (attr_q.inta),
    .cur_bhe_n (attr_q.bhe_n),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .start     (start),
    .req_mem   (req_mem),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ahs_out   (ahs_out),
    .ahs_oe    (ahs_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .inta_n    (inta_n),
    .den_n     (den_n),
    .dt_r      (dt_r),
    .m_io      (m_io),
    .bhe_n     (bhe_n),
    .ctl_oe    (ctl_oe),
    .hlda      (hlda)
  );

  assign req_ack = start;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
  parameter int HW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic          ad_oe,
  input logic          ahs_oe,
  input logic [HW-1:0] ahs_out,
  input logic          m_io,
  input logic          rd_n,
  input logic          wr_n,
  input logic          inta_n,
  input logic          ready_in,
  input logic          den_n,
  input logic          dt_r,
  input logic          hlda,
  input logic          ctl_oe,
  input logic          req_ack
);

  assert_ale_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_ale_drives_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && ahs_oe));

  assert_io_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !m_io) |-> (ahs_out == '0));

  assert_read_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);

  assert_wait_keeps_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rd_n) && !rd_n && !ready_in) |=> !rd_n);

  assert_den_off_in_t1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> den_n);

  assert_dir_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> dt_r);

  assert_dir_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !dt_r);

  assert_float_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ctl_oe && !ad_oe && !ahs_oe));

  assert_no_accept_in_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !req_ack);

endmodule

bind bus_cycle_ctrl bcc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ale      (ale),
  .ad_oe    (ad_oe),
  .ahs_oe   (ahs_oe),
  .ahs_out  (ahs_out),
  .m_io     (m_io),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .inta_n   (inta_n),
  .ready_in (ready_in),
  .den_n    (den_n),
  .dt_r     (dt_r),
  .hlda     (hlda),
  .ctl_oe   (ctl_oe),
  .req_ack  (req_ack)
);

// File: tb/tb_bus_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_bus_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_mem, req_write, req_byte, req_inta, req_lock, req_split;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ack, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        ready_in, hold_in, hlda;
  logic [15:0] ad_in, ad_out;
  logic        ad_oe;
  logic [3:0]  ahs_out;
  logic        ahs_oe, ale, rd_n, wr_n, inta_n, den_n, dt_r, m_io, bhe_n, ctl_oe;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  bus_cycle_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mem(req_mem),
    .req_write(req_write), .req_byte(req_byte), .req_inta(req_inta),
    .req_lock(req_lock), .req_split(req_split), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ack(req_ack), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ready_in(ready_in), .hold_in(hold_in), .hlda(hlda),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ahs_out(ahs_out),
    .ahs_oe(ahs_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
    .den_n(den_n), .dt_r(dt_r), .m_io(m_io), .bhe_n(bhe_n), .ctl_oe(ctl_oe)
  );

  task automatic chk(input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  // one complete cycle; caller is 1 ns after an edge, next edge accepts
  task automatic do_cycle(input bit mem, input bit wr, input bit byt, input bit ia,
                          input bit lk, input bit sp, input logic [19:0] addr,
                          input logic [15:0] wd, input logic [15:0] rd,
                          input int waits, input bit hold_t3);
    logic       exp_bhe;
    logic [2:0] exp_str;
    exp_bhe = ~(~byt | addr[0]);
    exp_str = {wr | ia, ~wr, ~ia};
    req_valid = 1'b1; req_mem = mem; req_write = wr; req_byte = byt;
    req_inta = ia; req_lock = lk; req_split = sp; req_addr = addr;
    req_wdata = wd; ad_in = rd; ready_in = (waits == 0);
    #0.5;
    chk("R13", "req_ack at accept", req_ack, 1);
    chk("R7", "m_io preview", m_io, mem);
    step;                                   // T1
    req_valid = 1'b0;
    chk("R1", "ale in T1", ale, 1);
    chk("R1", "ad_oe in T1", ad_oe, 1);
    chk("R1", "address low", ad_out, addr[15:0]);
    chk("R2", "upper field T1", ahs_out, mem ? addr[19:16] : 4'h0);
    chk("R8", "bhe_n", bhe_n, exp_bhe);
    chk("R6", "dt_r", dt_r, wr);
    chk("R3", "strobes idle in T1", {rd_n, wr_n, inta_n}, 3'b111);
    step;                                   // T2
    chk("R3", "strobes T2", {rd_n, wr_n, inta_n}, exp_str);
    chk("R3", "ad_oe T2", ad_oe, wr);
    if (wr) chk("R3", "write data", ad_out, wd);
    chk("R2", "upper field T2", ahs_out, 0);
    chk("R1", "ale low T2", ale, 0);
    chk("R5", "den_n early T2", den_n, 1);
    #2;
    chk("R5", "den_n mid T2", den_n, 0);
    step;                                   // T3
    if (hold_t3) hold_in = 1'b1;
    chk("R4", "strobes T3", {rd_n, wr_n, inta_n}, exp_str);
    for (int k = 0; k < waits; k++) begin
      step;                                 // wait state
      chk("R4", "strobes in wait", {rd_n, wr_n, inta_n}, exp_str);
      chk("R12", "no rsp in wait", rsp_valid, 0);
      ready_in = (k == waits - 1);
    end
    step;                                   // T4
    chk("R4", "strobes off T4", {rd_n, wr_n, inta_n}, 3'b111);
    chk("R12", "rsp_valid T4", rsp_valid, 1);
    if (!wr) chk("R12", "read data", rsp_rdata, rd);
    chk("R7", "m_io held T4", m_io, mem);
    chk("R5", "den_n early T4", den_n, 0);
    #2;
    chk("R5", "den_n mid T4", den_n, 1);
    ready_in = 1'b1;
  endtask

  task automatic drop_hold;
    hold_in = 1'b0;
    step; step;
    chk("R10", "hlda still high", hlda, 1);
    step;
    chk("R10", "ctl_oe back", ctl_oe, 1);
    #2;
    chk("R10", "hlda dropped", hlda, 0);
  endtask

  task automatic t_reset;
    chk("R1", "ale after reset", ale, 0);
    chk("R3", "strobes after reset", {rd_n, wr_n, inta_n}, 3'b111);
    chk("R5", "den_n after reset", den_n, 1);
    chk("R9", "hlda after reset", hlda, 0);
    chk("R12", "rsp_valid after reset", rsp_valid, 0);
    chk("R13", "req_ack after reset", req_ack, 0);
  endtask

  task automatic t_mem_read_waits;
    do_cycle(1, 0, 0, 0, 0, 0, 20'hA1234, 16'h0, 16'hBEEF, 2, 0);
    step;
  endtask

  task automatic t_io_write_odd_byte;
    do_cycle(0, 1, 1, 0, 0, 0, 20'h50081, 16'h5A00, 16'h0, 0, 0);
    step;
  endtask

  task automatic t_mem_read_even_byte;
    do_cycle(1, 0, 1, 0, 0, 0, 20'h3C0F2, 16'h0, 16'h00C3, 1, 0);
    step;
  endtask

  task automatic t_back_to_back;
    do_cycle(0, 1, 0, 0, 0, 0, 20'h00400, 16'h1357, 16'h0, 0, 0);
    chk("R7", "m_io keeps I/O in T4", m_io, 0);
    do_cycle(1, 0, 0, 0, 0, 0, 20'hF0010, 16'h0, 16'h2468, 0, 0);
    step;
  endtask

  task automatic t_inta;
    do_cycle(0, 0, 1, 1, 0, 0, 20'h00000, 16'h0, 16'h0021, 0, 0);
    step;
  endtask

  task automatic t_hold_idle;
    hold_in = 1'b1;
    step; step;
    chk("R9", "no hold before sync", ctl_oe, 1);
    chk("R9", "hlda low before sync", hlda, 0);
    step;
    chk("R9", "ctl floated", ctl_oe, 0);
    chk("R9", "ad floated", ad_oe, 0);
    chk("R9", "ahs floated", ahs_oe, 0);
    chk("R1", "ale low in hold", ale, 0);
    chk("R9", "hlda not yet", hlda, 0);
    req_valid = 1'b1; req_mem = 1'b1; req_write = 1'b0;
    #0.5;
    chk("R13", "no accept in hold", req_ack, 0);
    #1.5;
    chk("R9", "hlda at falling edge", hlda, 1);
    req_valid = 1'b0;
    drop_hold();
  endtask

  task automatic t_hold_early;
    hold_in = 1'b1;
    do_cycle(1, 0, 0, 0, 0, 0, 20'h12344, 16'h0, 16'h7777, 0, 0);
    step;
    chk("R11", "released after T4", ctl_oe, 0);
    chk("R11", "no T1", ale, 0);
    #2;
    chk("R9", "hlda up", hlda, 1);
    drop_hold();
  endtask

  task automatic t_hold_blocked(input int kind);
    hold_in = 1'b1;
    do_cycle(1, 0, kind == 1, kind == 2, kind == 0, kind == 1,
             20'h20001, 16'h0, 16'h1111, 0, 0);
    do_cycle(1, 1, 0, 0, 0, 0, 20'h20002, 16'h9999, 16'h0, 0, 0);
    step;
    chk("R11", "released after plain cycle", ctl_oe, 0);
    #2;
    chk("R11", "hlda after plain cycle", hlda, 1);
    drop_hold();
  endtask

  task automatic t_hold_late;
    do_cycle(1, 0, 0, 0, 0, 0, 20'h44440, 16'h0, 16'h4444, 0, 1);
    do_cycle(0, 0, 0, 0, 0, 0, 20'h00060, 16'h0, 16'h0606, 0, 0);
    step;
    chk("R11", "late hold released next", ctl_oe, 0);
    #2;
    chk("R11", "hlda after next", hlda, 1);
    drop_hold();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mem = 1'b0; req_write = 1'b0;
    req_byte = 1'b0; req_inta = 1'b0; req_lock = 1'b0; req_split = 1'b0;
    req_addr = '0; req_wdata = '0; ready_in = 1'b1; hold_in = 1'b0; ad_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step;
    t_reset();
    t_mem_read_waits();
    t_io_write_odd_byte();
    t_mem_read_even_byte();
    t_back_to_back();
    t_inta();
    t_hold_idle();
    t_hold_early();
    for (int kd = 0; kd < 3; kd++) t_hold_blocked(kd);
    t_hold_late();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule